// File: doc/BRIEF.md
# Phase-Coded Link Receiver

This block is the receiving end of a transient-tolerant point-to-point link. The link has one reference pair and one symbol pair per data bit. The sender steps the reference pair through a two-bit Gray cycle. For each bit it drives a symbol pair that either copies the reference (the bit is 0) or is its bitwise inverse (the bit is 1). A glitch that upsets one symbol wire leaves a pair that is neither, so the receiver can reject it instead of turning it into wrong data.

All wires first pass a two-flop synchroniser. A reference tracker compares the synchronised reference with the value it expects. A correct Gray step opens a collection step; a skipped or backward move is an error. While a step is open, every symbol pair is classified against the reference, and the per-bit verdicts are ANDed. The data word is released with a one-cycle strobe only when every pair is valid. If that does not happen within `TIMEOUT` cycles, a sticky error flag is raised and the step is dropped.

The control is a two-state machine:
- **ST_IDLE** waits for a reference step. The transition *open* (on a correct Gray step) leads to ST_COLLECT.
- **ST_COLLECT** waits for a complete word. Its transitions are:
  - *release* (all pairs valid): strobe the word and return to ST_IDLE.
  - *expire* (the timeout counter reaches `TIMEOUT-1`): set the error flag and return to ST_IDLE.
  - *abort* (a bad reference move): set the error flag and return to ST_IDLE.
  - *restart* (a further correct step arrives before the word is complete): set the error flag and stay in ST_COLLECT for the new step.

Top module: `phase_link_rx`

## Requirements
- R1: Reference and symbol inputs pass two synchronising flops. With valid symbols driven together with a correct reference step, `word_vld` is high in the fourth clock cycle after the inputs change.
- R2: A correct reference step follows the order 00 → 01 → 11 → 10 → 00. Each correct step opens exactly one collection step.
- R3: Bit i uses pair `sym_in[2i+1:2i]`. A pair equal to the reference decodes as data 0.
- R4: A pair equal to the bitwise inverse of the reference decodes as data 1.
- R5: A pair that is neither equal to nor the inverse of the reference is invalid. The word is released only when all pairs are valid, so a corrupted pair that is corrected within the window still yields the correct word.
- R6: Each correct reference step releases at most one word, as a one-cycle `word_vld` pulse. `word_out` changes only when the word is released and holds its value otherwise.
- R7: A reference move that skips a step or goes backwards opens no step and releases no word. It sets `link_err`, which stays set until reset.
- R8: If not all pairs are valid within `TIMEOUT` cycles (default 8) after a step opens, `link_err` is set and no word is released for that step. With the defaults, the flag appears 11 cycles after the reference change.
- R9: After reset the expected reference is 00, and `word_vld`, `link_err` and `word_out` are 0. No pulse occurs before the first correct step.
- R10: A further correct reference step arriving while a step is still open sets `link_err`, abandons the old step and collects the word of the new step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 2 | Reference pair from the link |
| sym_in | input | 2*N_BITS | Symbol pairs; bit i on [2i+1:2i] |
| word_out | output | N_BITS | Last released data word |
| word_vld | output | 1 | One-cycle strobe for a released word |
| link_err | output | 1 | Sticky link error flag |

## Verification
A clean step needs four clock edges from the input change to the strobe: two synchroniser flops, then the tracker opening the step, then the registered release. The bench drives at the falling edge, counts those four rising edges and samples at the next falling edge; it confirms the strobe is gone one cycle later. A bad move shows on `link_err` after the third edge, and an expiry after edge 3+`TIMEOUT`. Those checks walk edge by edge, confirming the flag is still clear one edge early. Cases whose latency depends on when a corrupted pair is repaired poll for the strobe within a bounded number of cycles.

// File: rtl/phase_link_pkg.sv
package phase_link_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_COLLECT
    } rx_state_e;

    // successor in the reference Gray cycle 00 -> 01 -> 11 -> 10 -> 00
    function automatic logic [1:0] gray_succ(input logic [1:0] g);
        logic [1:0] r;
        unique case (g)
            2'b00:   r = 2'b01;
            2'b01:   r = 2'b11;
            2'b11:   r = 2'b10;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/plr_sync.sv
module plr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/plr_ref_track.sv
module plr_ref_track
    import phase_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_s,
    output logic [1:0] ref_cur,
    output logic       step_ok,
    output logic       step_bad
);
    logic moved;

    always_comb begin
        moved    = (ref_s != ref_cur);
        step_ok  = moved && (ref_s == gray_succ(ref_cur));
        step_bad = moved && !step_ok;
    end

    // follow the wire on every move so one bad move flags once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ref_cur <= 2'b00;
        else if (moved) ref_cur <= ref_s;
    end
endmodule

// File: rtl/plr_pair_decode.sv
module plr_pair_decode (
    input  logic [1:0] ref_v,
    input  logic [1:0] pair,
    output logic       bit_v,
    output logic       bit_ok
);
    always_comb begin
        bit_v  = (pair == ~ref_v);
        bit_ok = (pair == ref_v) || (pair == ~ref_v);
    end
endmodule

// File: rtl/plr_word_decode.sv
module plr_word_decode #(
    parameter int N_BITS = 8
) (
    input  logic [1:0]          ref_v,
    input  logic [2*N_BITS-1:0] sym,
    output logic [N_BITS-1:0]   word,
    output logic                all_ok
);
    logic [N_BITS-1:0] oks;

    for (genvar i = 0; i < N_BITS; i++) begin : g_bit
        plr_pair_decode u_pair (
            .ref_v  (ref_v),
            .pair   (sym[2*i+1:2*i]),
            .bit_v  (word[i]),
            .bit_ok (oks[i])
        );
    end

    assign all_ok = &oks;
endmodule

// File: rtl/phase_link_rx.sv
module phase_link_rx
    import phase_link_pkg::*;
#(
    parameter int N_BITS      = 8,
    parameter int TIMEOUT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ref_in,
    input  logic [2*N_BITS-1:0] sym_in,
    output logic [N_BITS-1:0]   word_out,
    output logic                word_vld,
    output logic                link_err
);
    localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic [1:0]          ref_s, ref_cur;
    logic [2*N_BITS-1:0] sym_s;
    logic                step_ok, step_bad, all_ok;
    logic [N_BITS-1:0]   word_dec;

    rx_state_e           st, st_nx;
    logic [CNT_W-1:0]    cnt, cnt_nx;
    logic                rel, expire, restart;

    plr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ref (
        .clk(clk), .rst_n(rst_n), .d(ref_in), .q(ref_s)
    );

    plr_sync #(.W(2*N_BITS), .STAGES(SYNC_STAGES)) u_sync_sym (
        .clk(clk), .rst_n(rst_n), .d(sym_in), .q(sym_s)
    );

    plr_ref_track u_track (
        .clk(clk), .rst_n(rst_n), .ref_s(ref_s),
        .ref_cur(ref_cur), .step_ok(step_ok), .step_bad(step_bad)
    );

    plr_word_decode #(.N_BITS(N_BITS)) u_dec (
        .ref_v(ref_cur), .sym(sym_s), .word(word_dec), .all_ok(all_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        rel     = 1'b0;
        expire  = 1'b0;
        restart = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (step_ok) begin              // open
                    st_nx  = ST_COLLECT;
                    cnt_nx = '0;
                end
            end
            ST_COLLECT: begin
                if (step_bad) begin             // abort
                    st_nx = ST_IDLE;
                end else if (step_ok) begin     // restart
                    restart = 1'b1;
                    cnt_nx  = '0;
                end else if (all_ok) begin      // release
                    rel   = 1'b1;
                    st_nx = ST_IDLE;
                end else if (cnt == CNT_LAST) begin // expire
                    expire = 1'b1;
                    st_nx  = ST_IDLE;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            word_out <= '0;
            link_err <= 1'b0;
        end else begin
            word_vld <= rel;
            if (rel) word_out <= word_dec;
            link_err <= link_err | step_bad | expire | restart;
        end
    end
endmodule

// File: rtl/phase_link_rx_chk.sv
module phase_link_rx_chk #(
    parameter int N_BITS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              word_vld,
    input logic              link_err,
    input logic [N_BITS-1:0] word_out,
    input logic              step_ok,
    input logic              step_bad,
    input logic              all_ok
);
    logic seen_step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seen_step <= 1'b0;
        else if (step_ok) seen_step <= 1'b1;
    end

    assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld |-> $stable(word_out));

    assert_release_needs_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(all_ok));

    assert_bad_move_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_bad |=> link_err);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> link_err);

    assert_no_pulse_before_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_step |-> !word_vld);
endmodule

bind phase_link_rx phase_link_rx_chk #(.N_BITS(N_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .link_err (link_err),
    .word_out (word_out),
    .step_ok  (step_ok),
    .step_bad (step_bad),
    .all_ok   (all_ok)
);

// File: tb/sim_phase_link_rx.sv
`timescale 1ns/1ps
module sim_phase_link_rx;
    localparam int N   = 8;
    localparam int TMO = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       ref_in = 2'b00;
    logic [2*N-1:0]   sym_in = '0;
    logic [N-1:0]     word_out;
    logic             word_vld, link_err;

    int total = 0;
    int bad   = 0;
    logic [1:0] mref = 2'b00;

    always #4 clk = ~clk;   // 125 MHz

    phase_link_rx #(.N_BITS(N), .TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sym_in(sym_in),
        .word_out(word_out), .word_vld(word_vld), .link_err(link_err)
    );

    function automatic logic [1:0] nxt(input logic [1:0] g);
        case (g)
            2'b00: return 2'b01;
            2'b01: return 2'b11;
            2'b11: return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [2*N-1:0] enc(input logic [N-1:0] w, input logic [1:0] r);
        logic [2*N-1:0] s;
        for (int i = 0; i < N; i++) s[2*i +: 2] = w[i] ? ~r : r;
        return s;
    endfunction

    function automatic logic [2*N-1:0] spoil(input logic [2*N-1:0] s, input int b,
                                             input logic [1:0] r);
        logic [2*N-1:0] t = s;
        t[2*b +: 2] = {r[1], ~r[0]};
        return t;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 2'b00; sym_in = '0; mref = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_vld(input int maxc, output bit got);
        got = 1'b0;
        for (int c = 0; c < maxc && !got; c++) begin
            @(negedge clk);
            if (word_vld) got = 1'b1;
        end
    endtask

    // clean step with exact latency check
    task automatic clean_step(input logic [N-1:0] w, input string req);
        @(negedge clk);
        mref = nxt(mref);
        ref_in = mref; sym_in = enc(w, mref);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word_vld == 1'b0, "R1", "early strobe", word_vld, 0);
        @(posedge clk); @(negedge clk);
        chk(word_vld == 1'b1, "R1", "strobe at 4th edge", word_vld, 1);
        chk(word_out == w, req, "word", word_out, w);
        @(negedge clk);
        chk(word_vld == 1'b0, "R6", "pulse width", word_vld, 0);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit got;
        logic [N-1:0] w;
        logic [2*N-1:0] s;
        void'($urandom(32'd4242));

        do_reset();
        chk(word_vld == 0 && link_err == 0 && word_out == 0, "R9", "reset outputs",
            {word_vld, link_err, word_out}, 0);
        repeat (10) begin
            @(negedge clk);
            if (word_vld) chk(0, "R9", "pulse before first step", 1, 0);
        end
        chk(word_vld == 0, "R9", "quiet before step", word_vld, 0);

        clean_step('0, "R3");
        clean_step('1, "R4");
        clean_step(8'hA5, "R3");
        clean_step(8'h3C, "R4");

        // one pulse per step: inputs held, no second strobe
        got = 1'b0;
        repeat (12) begin @(negedge clk); if (word_vld) got = 1'b1; end
        chk(!got, "R6", "repeat strobe without step", got, 0);
        chk(word_out == 8'h3C, "R6", "word held", word_out, 8'h3C);

        // full Gray cycle, random words
        for (int k = 0; k < 40; k++) begin
            w = N'($urandom);
            clean_step(w, "R2");
        end
        chk(link_err == 0, "R2", "no error on clean cycle", link_err, 0);

        // transient on a pair repaired inside window
        for (int k = 0; k < 6; k++) begin
            w = N'($urandom);
            @(negedge clk);
            mref = nxt(mref);
            s = enc(w, mref);
            ref_in = mref; sym_in = spoil(s, $urandom_range(N-1), mref);
            repeat (4) @(negedge clk);
            chk(word_vld == 0, "R5", "invalid pair blocks word", word_vld, 0);
            sym_in = s;
            wait_vld(6, got);
            chk(got, "R5", "word after repair", got, 1);
            chk(word_out == w, "R5", "repaired word", word_out, w);
        end
        chk(link_err == 0, "R5", "no error when repaired in time", link_err, 0);

        // R10: new step while old open
        @(negedge clk);
        mref = nxt(mref);
        ref_in = mref; sym_in = spoil(enc(8'h11, mref), 2, mref);
        repeat (4) @(negedge clk);
        mref = nxt(mref);
        ref_in = mref; sym_in = enc(8'hC3, mref);
        wait_vld(8, got);
        chk(got, "R10", "new step word released", got, 1);
        chk(word_out == 8'hC3, "R10", "new step word", word_out, 8'hC3);
        @(negedge clk);
        chk(link_err == 1, "R10", "abandoned step flagged", link_err, 1);

        // R7: skip
        do_reset();
        @(negedge clk);
        ref_in = 2'b11; sym_in = enc(8'hFF, 2'b11); mref = 2'b11;
        repeat (2) @(posedge clk); @(negedge clk);
        chk(link_err == 0, "R7", "flag not yet", link_err, 0);
        @(posedge clk); @(negedge clk);
        chk(link_err == 1, "R7", "skip flagged", link_err, 1);
        got = 1'b0;
        repeat (8) begin @(negedge clk); if (word_vld) got = 1'b1; end
        chk(!got, "R7", "no word on skip", got, 0);
        chk(link_err == 1, "R7", "flag sticky", link_err, 1);

        // R7: backward
        do_reset();
        clean_step(8'h5A, "R3");
        @(negedge clk);
        ref_in = 2'b00; sym_in = enc(8'h0F, 2'b00); mref = 2'b00;
        got = 1'b0;
        repeat (8) begin @(negedge clk); if (word_vld) got = 1'b1; end
        chk(!got, "R7", "no word on backward", got, 0);
        chk(link_err == 1, "R7", "backward flagged", link_err, 1);
        chk(word_out == 8'h5A, "R7", "word untouched", word_out, 8'h5A);

        // R8: timeout
        do_reset();
        @(negedge clk);
        mref = 2'b01;
        ref_in = mref; sym_in = spoil(enc(8'h77, mref), 5, mref);
        for (int e = 1; e <= 3 + TMO; e++) begin
            @(posedge clk); @(negedge clk);
            if (word_vld) chk(0, "R8", "word during timeout", 1, 0);
            if (e == 2 + TMO) chk(link_err == 0, "R8", "flag one edge early", link_err, 0);
            if (e == 3 + TMO) chk(link_err == 1, "R8", "timeout flag", link_err, 1);
        end
        sym_in = enc(8'h77, mref);
        got = 1'b0;
        repeat (8) begin @(negedge clk); if (word_vld) got = 1'b1; end
        chk(!got, "R8", "dropped step not released late", got, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule